// File: doc/BRIEF.md
# Serial NVRAM Command Controller

This block drives a three-wire serial EEPROM or NVRAM as bus master, using a chip select, a serial clock, a data line toward the device and a data line back from it. A host pulses `start_i` while the block is idle. In command mode the block selects the device, shifts out an 11-bit command word, and then deselects the device. The word is a 3-bit opcode followed by an 8-bit register address.

In poll mode the block selects the device and samples the device's ready line at a fixed interval, for a bounded number of attempts. It then deselects the device and reports success or timeout. A host issues a poll after a write or erase command to wait out the device's internal write cycle. With the default dividers at a 50 MHz clock, one step is 0.5 us and one poll interval is 100 us. With 200 retries the poll covers about 20 ms, which is twice the device's 10 ms worst-case write time.

Every change on the three device pins is one "step" that lasts `HALF_DIV` system clocks. All step orders are fixed, so the device always sees clean setup and hold around its rising-edge sampling.

Top module: `nvc_ctrl`

## Requirements
- R1: After reset, `cs_o`, `sclk_o`, `sdo_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: The command word is `{op_i[2:0], addr_i[7:0]}`, 11 bits, sent most significant bit first: op bit 2 goes first and address bit 0 goes last.
- R3: A start accepted at clock edge E first clears all three pins low at E. Chip select then rises at E+HALF_DIV, and the serial clock rises at E+2*HALF_DIV.
- R4: Each word bit takes three steps: data is driven while the clock is high, the clock falls, then the clock rises (the device samples here). Data changes only while the clock is high and steady.
- R5: After the last bit, data is forced low. Deselect then drives the clock low, drops chip select, and drives the clock high. Chip select changes only while the clock is low and steady.
- R6: In command mode, `done_o` pulses at E+40*HALF_DIV with `err_o` low, and `busy_o` falls on that same edge.
- R7: In poll mode (`poll_i` high at start), the select steps of R3 run, and the pins then hold chip select high with the clock high. `sdi_i` is sampled at the edges E+3*HALF_DIV+1+n*POLL_DIV, for n = 0..POLL_LIMIT.
- R8: When sample n reads high, the deselect steps of R5 begin on that edge, and `done_o` pulses with `err_o` low 3*HALF_DIV cycles later.
- R9: When all POLL_LIMIT+1 samples read low, the poll ends as in R8 with n = POLL_LIMIT, but `err_o` is high with `done_o`.
- R10: `busy_o` is high from the edge that accepts the start until completion. A start pulse while busy is ignored: the running word and its timing are unchanged, and no new operation follows.
- R11: `done_o` lasts exactly one cycle, and `err_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| poll_i | input | 1 | Mode at start: 0 sends a command word, 1 runs a ready poll |
| op_i | input | OP_WIDTH | Opcode for the command word |
| addr_i | input | ADR_WIDTH | Register address for the command word |
| sdi_i | input | 1 | Ready/data line from the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout, valid with `done_o` |
| cs_o | output | 1 | Device chip select, active high |
| sclk_o | output | 1 | Serial clock to the device |
| sdo_o | output | 1 | Serial data to the device |

## Verification
A command takes exactly 40 steps. The bench checks the pin triple once per step, at the negative edge after the edge that set that step, where it compares the triple against a step table computed from the opcode and address. It then expects `done_o` exactly 40*HALF_DIV cycles after the accepting edge, and expects `done_o` low one cycle later. For polls, the bench raises the ready line one cycle before the edge of chosen sample n and counts cycles until `done_o`, expecting 6*HALF_DIV+1+n*POLL_DIV. A timeout is the case n = POLL_LIMIT with `err_o` high.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    localparam int OP_W_DEF  = 3;
    localparam int ADR_W_DEF = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR,
        ST_SEL,
        ST_CKH,
        ST_BIT_D,
        ST_BIT_L,
        ST_BIT_H,
        ST_TAIL,
        ST_POLL,
        ST_DES_L,
        ST_DES_CS,
        ST_DES_H
    } state_t;

    typedef struct packed {
        logic cs;
        logic sclk;
        logic sdo;
    } pins_t;

    localparam pins_t PINS_OFF = '{cs: 1'b0, sclk: 1'b0, sdo: 1'b0};

    // States whose length is one fixed step of the half-period divider
    function automatic logic is_timed(state_t s);
        return (s != ST_IDLE) && (s != ST_POLL);
    endfunction

endpackage

// File: rtl/nvc_divider.sv
module nvc_divider #(
    parameter int COUNT        = 4,
    parameter bit HIT_AT_START = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int            CW   = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (HIT_AT_START) begin : g_first
            assign hit = run && (cnt_q == '0);
        end else begin : g_last
            assign hit = run && (cnt_q == LAST);
        end
    endgenerate

    // R7: interval counter stays inside its period
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/nvc_shifter.sv
module nvc_shifter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         msb_next
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (load)
            sh_q <= din;
        else if (shift)
            sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign msb      = sh_q[W-1];
    assign msb_next = sh_q[W-2];

    // R10: a load never coincides with a shift
    p_no_load_shift_r10: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/nvc_attempts.sv
module nvc_attempts #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int            CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CAP);

    // R9: never more failed samples than the limit
    p_tries_cap_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CAP);

    p_no_bump_at_cap_r9: assert property (@(posedge clk) disable iff (rst)
        at_limit |-> !bump);

endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
    import nvc_pkg::*;
#(
    parameter int OP_WIDTH   = OP_W_DEF,
    parameter int ADR_WIDTH  = ADR_W_DEF,
    parameter int HALF_DIV   = 25,
    parameter int POLL_DIV   = 5000,
    parameter int POLL_LIMIT = 200
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 poll_i,
    input  logic [OP_WIDTH-1:0]  op_i,
    input  logic [ADR_WIDTH-1:0] addr_i,
    input  logic                 sdi_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 cs_o,
    output logic                 sclk_o,
    output logic                 sdo_o
);
    localparam int            FRAME_W  = OP_WIDTH + ADR_WIDTH;
    localparam int            BW       = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    state_t        st_q, st_d;
    pins_t         pins_q, pins_d;
    logic          mode_q, mode_d;
    logic          fail_q, fail_d;
    logic          done_q, done_d;
    logic          err_q, err_d;
    logic [BW-1:0] bit_q, bit_d;

    logic step_hit, poll_hit, at_limit;
    logic ld, sh, msb, msb_nx;
    logic tries_clr, tries_bump;

    nvc_divider #(.COUNT(HALF_DIV), .HIT_AT_START(1'b0)) u_step (
        .clk (clk),
        .rst (rst),
        .run (is_timed(st_q)),
        .hit (step_hit)
    );

    nvc_divider #(.COUNT(POLL_DIV), .HIT_AT_START(1'b1)) u_poll (
        .clk (clk),
        .rst (rst),
        .run (st_q == ST_POLL),
        .hit (poll_hit)
    );

    nvc_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .shift    (sh),
        .din      ({op_i, addr_i}),
        .msb      (msb),
        .msb_next (msb_nx)
    );

    nvc_attempts #(.LIMIT(POLL_LIMIT)) u_tries (
        .clk      (clk),
        .rst      (rst),
        .clear    (tries_clr),
        .bump     (tries_bump),
        .at_limit (at_limit)
    );

    always_comb begin
        st_d       = st_q;
        pins_d     = pins_q;
        mode_d     = mode_q;
        fail_d     = fail_q;
        bit_d      = bit_q;
        done_d     = 1'b0;
        err_d      = 1'b0;
        ld         = 1'b0;
        sh         = 1'b0;
        tries_clr  = 1'b0;
        tries_bump = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                st_d      = ST_CLR;
                pins_d    = PINS_OFF;
                mode_d    = poll_i;
                fail_d    = 1'b0;
                bit_d     = '0;
                ld        = 1'b1;
                tries_clr = 1'b1;
            end
            ST_CLR: if (step_hit) begin
                st_d      = ST_SEL;
                pins_d.cs = 1'b1;
            end
            ST_SEL: if (step_hit) begin
                st_d        = ST_CKH;
                pins_d.sclk = 1'b1;
            end
            ST_CKH: if (step_hit) begin
                if (mode_q) begin
                    st_d = ST_POLL;
                end else begin
                    st_d       = ST_BIT_D;
                    pins_d.sdo = msb;
                end
            end
            ST_BIT_D: if (step_hit) begin
                st_d        = ST_BIT_L;
                pins_d.sclk = 1'b0;
            end
            ST_BIT_L: if (step_hit) begin
                st_d        = ST_BIT_H;
                pins_d.sclk = 1'b1;
            end
            ST_BIT_H: if (step_hit) begin
                if (bit_q == LAST_BIT) begin
                    st_d       = ST_TAIL;
                    pins_d.sdo = 1'b0;
                end else begin
                    st_d       = ST_BIT_D;
                    pins_d.sdo = msb_nx;
                    sh         = 1'b1;
                    bit_d      = bit_q + 1'b1;
                end
            end
            ST_TAIL: if (step_hit) begin
                st_d        = ST_DES_L;
                pins_d.sclk = 1'b0;
            end
            ST_POLL: if (poll_hit) begin
                if (sdi_i) begin
                    st_d        = ST_DES_L;
                    pins_d.sclk = 1'b0;
                end else if (at_limit) begin
                    st_d        = ST_DES_L;
                    pins_d.sclk = 1'b0;
                    fail_d      = 1'b1;
                end else begin
                    tries_bump = 1'b1;
                end
            end
            ST_DES_L: if (step_hit) begin
                st_d      = ST_DES_CS;
                pins_d.cs = 1'b0;
            end
            ST_DES_CS: if (step_hit) begin
                st_d        = ST_DES_H;
                pins_d.sclk = 1'b1;
            end
            ST_DES_H: if (step_hit) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
                err_d  = fail_q;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pins_q <= PINS_OFF;
            mode_q <= 1'b0;
            fail_q <= 1'b0;
            bit_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            pins_q <= pins_d;
            mode_q <= mode_d;
            fail_q <= fail_d;
            bit_q  <= bit_d;
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    assign busy_o = (st_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign cs_o   = pins_q.cs;
    assign sclk_o = pins_q.sclk;
    assign sdo_o  = pins_q.sdo;

    // R4: data moves only while the clock is high and not moving
    p_sdo_when_high_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo_o) |-> (sclk_o && $stable(sclk_o)));

    // R5: select moves only while the clock is low and not moving
    p_cs_quiet_clk_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_o) |-> (!sclk_o && $stable(sclk_o)));

    // R6: busy ends only with a completion pulse
    p_busy_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R10: mode chosen at start holds for the whole operation
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));

    // R11: completion pulse is a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11: error flag only together with completion
    p_err_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R8: polling keeps the device selected with the clock parked high
    p_poll_selected_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_POLL) |-> (cs_o && sclk_o));

endmodule

// File: tb/sim_nvc_ctrl.sv
module sim_nvc_ctrl;

    localparam int H = 2;
    localparam int P = 5;
    localparam int L = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       poll = 1'b0;
    logic       sdi = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] adr = '0;
    logic       busy, done, err, cs, sclk, sdo;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nvc_ctrl #(
        .OP_WIDTH(3), .ADR_WIDTH(8),
        .HALF_DIV(H), .POLL_DIV(P), .POLL_LIMIT(L)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start), .poll_i(poll),
        .op_i(op), .addr_i(adr), .sdi_i(sdi),
        .busy_o(busy), .done_o(done), .err_o(err),
        .cs_o(cs), .sclk_o(sclk), .sdo_o(sdo)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pins();
        return {29'd0, cs, sclk, sdo};
    endfunction

    // expected {cs,sclk,sdo} at step k of a command
    function automatic int exp_pins(int k, logic [10:0] fr);
        int i, ph;
        logic b;
        if (k == 0) return 3'b000;
        if (k == 1) return 3'b100;
        if (k == 2) return 3'b110;
        if (k < 36) begin
            i  = (k - 3) / 3;
            ph = (k - 3) % 3;
            b  = fr[10 - i];
            if (ph == 1) return {2'b10, b};
            return {2'b11, b};
        end
        if (k == 36) return 3'b110;
        if (k == 37) return 3'b100;
        if (k == 38) return 3'b000;
        return 3'b010;
    endfunction

    task automatic run_cmd(logic [2:0] o, logic [7:0] a, bit poke);
        logic [10:0] fr;
        fr = {o, a};
        @(negedge clk);
        op = o; adr = a; poll = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (k < 3)        check("R3 select step", pins(), exp_pins(k, fr));
            else if (k < 36)  check("R2 R4 word bit step", pins(), exp_pins(k, fr));
            else              check("R5 tail/deselect step", pins(), exp_pins(k, fr));
            check("R10 busy during command", busy, 1);
            check("R11 no early done", done, 0);
            if (poke && k == 10) begin
                start = 1'b1; op = ~o; adr = ~a; poll = 1'b1;
            end
            for (int j = 0; j < H; j++) begin
                @(negedge clk);
                start = 1'b0;
            end
        end
        check("R6 done at 40 steps", done, 1);
        check("R6 busy falls with done", busy, 0);
        check("R6 no error on command", err, 0);
        @(negedge clk);
        check("R11 done one cycle", done, 0);
        check("R10 ignored start gives no new op", busy, 0);
    endtask

    // n < 0 : ready never rises
    task automatic run_poll(int n);
        int t, set_t, exp_n;
        @(negedge clk);
        poll = 1'b1; start = 1'b1; sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        set_t = (n >= 0) ? (3*H + n*P) : -1;
        t = 0;
        forever begin
            if (done) break;
            if (t == set_t) sdi = 1'b1;
            if (t == 0)   check("R3 poll clears pins", pins(), 3'b000);
            if (t == 3*H) check("R7 poll selected, clock high", pins(), 3'b110);
            check("R10 busy during poll", busy, 1);
            if (t > 4000) break;
            @(negedge clk);
            t++;
        end
        exp_n = (n >= 0) ? n : L;
        if (n >= 0) begin
            check("R8 ready poll completion time", t, 6*H + 1 + exp_n*P);
            check("R8 ready poll no error", err, 0);
        end else begin
            check("R9 timeout completion time", t, 6*H + 1 + exp_n*P);
            check("R9 timeout error flag", err, 1);
        end
        check("R8 deselected after poll", pins(), 3'b010);
        @(negedge clk);
        check("R11 done one cycle after poll", done, 0);
        check("R11 error cleared", err, 0);
        sdi = 1'b0;
        poll = 1'b0;
    endtask

    initial begin
        logic [7:0] addrs [6];
        addrs = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset cs", cs, 0);
        check("R1 reset sclk", sclk, 0);
        check("R1 reset sdo", sdo, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset err", err, 0);
        for (int o = 0; o < 8; o++)
            for (int a = 0; a < 6; a++)
                run_cmd(3'(o), addrs[a], 1'b0);
        run_cmd(3'b101, 8'h3C, 1'b1);
        for (int n = 0; n <= L; n++)
            run_poll(n);
        run_poll(-1);
        run_cmd(3'b010, 8'hC3, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule